// File: doc/BRIEF.md
# Register Micro-Operation Unit

This unit carries out the register group of an 18-bit-word processor (17 data bits plus parity, parity not handled here). An instruction whose five-bit opcode field is zero needs no memory cycle. Its low bits are a set of micro-operation enables, and several of them may be set in one word. A two-bit mode field chooses which of three enable groups those bits mean. A select bit chooses whether register A or register B is the operand.

The unit takes the instruction word, both registers, the carry and greater-than flags and the front-panel switch value. It produces the updated registers, the updated flags and a skip request for the sequencer. All of these are captured in output registers on the clock edge that samples the inputs, so results appear one cycle later.

Within a word, operations apply in a fixed order: clear, switch merge, complement, increment/decrement, shift/rotate, half swap, sign-bit clear, sign-bit complement. Skip tests always look at the final values.

Top module: `regop_unit`

## Requirements
- R1: While `rstN` is low, every output register holds zero.
- R2: Each result appears on the outputs one clock after the inputs are sampled. Pass-through means the registers and flags are copied unchanged and skip is 0. This applies when the opcode field `instr[16:12]` is nonzero, and also when the mode field `instr[11:10]` is 00.
- R3: `instr[9]`=1 selects register A and 0 selects register B. The register that is not selected passes through unchanged.
- R4: Mode 01 (shift group). `instr[2]` adds 1 and `instr[3]` subtracts 1, modulo 2^17. When both are set, the value is unchanged.
- R5: Mode 01. `instr[8]` clears carry first. After increment/decrement, `instr[6]` shifts, with `instr[7]`=1 meaning left. A left shift puts bit 16 into carry and a 0 into bit 0. A right shift puts bit 0 into carry and a 0 into bit 16.
- R6: Mode 01. `instr[5]` rotates, and it overrides `instr[6]`. With `instr[4]`=0 the rotate is a 17-bit circular rotate and carry is kept. With `instr[4]`=1 the rotate is 18 bits through carry.
- R7: Mode 01. The unit skips if either enabled test holds on the final value: `instr[1]` tests for bit 15 = 0, and `instr[0]` tests for bit 0 = 0.
- R8: Mode 10 register operations, applied in this order: `instr[8]` clear, `instr[0]` OR in the switches, `instr[7]` one's complement, `instr[3]` half swap, `instr[2]` clear bit 16, `instr[1]` complement bit 16. The half swap exchanges bits 16..9 with bits 7..0 and leaves bit 8 in place.
- R9: Mode 10 carry and skip: `instr[6]` clears carry, then `instr[5]` complements it, and `instr[4]` skips unconditionally.
- R10: Mode 11 alter operations: `instr[1]` clears the register, then `instr[0]` one's-complements it, and `instr[2]` clears GT. Carry is unchanged, and GT changes only in this mode.
- R11: Mode 11 skip. The tests are `instr[7]` negative (bit 16 set), `instr[6]` nonzero, `instr[5]` carry set and `instr[3]` GT set, all on the final values; `instr[4]` is ignored. With sense `instr[8]`=1 the unit skips if any enabled test holds. With sense 0 it skips only if at least one test is enabled and none of the enabled tests holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instr | input | 17 | Instruction word |
| aIn | input | 17 | Register A current value |
| bIn | input | 17 | Register B current value |
| swIn | input | 17 | Switch register value |
| carryIn | input | 1 | Carry flag current value |
| gtIn | input | 1 | Greater-than flag current value |
| aOut | output | 17 | Register A new value |
| bOut | output | 17 | Register B new value |
| carryOut | output | 1 | Carry flag new value |
| gtOut | output | 1 | Greater-than flag new value |
| skipOut | output | 1 | Skip-next-instruction request |

## Verification
Some properties are checked by assertions on every cycle:
- pass-through for foreign opcodes and mode 00;
- preservation of the unselected register;
- GT left alone outside mode 11;
- carry left alone inside mode 11;
- wrap-around of a lone increment;
- the unconditional skip and the GT clear.

Other behaviour needs the bench's scenarios, because the expected result depends on how several enables combine:
- the ordering of combined enables;
- the direction and carry handling of shifts and rotates;
- the bit placement of the half swap;
- the reversed-sense skip rule, including the case with no test enabled.

// File: rtl/regop_pkg.sv
package regop_pkg;

  typedef enum logic [1:0] {
    MODE_MISC   = 2'b00,
    MODE_SHIFT  = 2'b01,
    MODE_CLRCPL = 2'b10,
    MODE_ALTER  = 2'b11
  } mode_e;

  typedef struct packed {
    logic selA;
    logic clrReg;
    logic orSw;
    logic cplReg;
    logic incReg;
    logic decReg;
    logic shiftEn;
    logic rotEn;
    logic thruCarry;
    logic leftDir;
    logic swapHalves;
    logic clrSign;
    logic cplSign;
    logic clrCarry;
    logic cplCarry;
    logic clrGt;
    logic skipAlways;
    logic testBit15Zero;
    logic testBit0Zero;
    logic testNeg;
    logic testNonZero;
    logic testCarry;
    logic testGt;
    logic senseTrue;
  } strobes_t;

endpackage

// File: rtl/regop_ctrl.sv
module regop_ctrl
  import regop_pkg::*;
#(
  parameter int INSTR_W = 17
) (
  input  logic [INSTR_W-1:0] instr,
  output strobes_t           strobes
);
  localparam int OPC_LO = 12;

  logic  isRegGroup;
  mode_e mode;

  assign isRegGroup = (instr[INSTR_W-1:OPC_LO] == '0);
  assign mode       = mode_e'(instr[11:10]);

  always_comb begin
    strobes      = '0;
    strobes.selA = instr[9];
    if (isRegGroup) begin
      unique case (mode)
        MODE_SHIFT: begin
          strobes.clrCarry      = instr[8];
          strobes.leftDir       = instr[7];
          strobes.shiftEn       = instr[6];
          strobes.rotEn         = instr[5];
          strobes.thruCarry     = instr[4];
          strobes.decReg        = instr[3];
          strobes.incReg        = instr[2];
          strobes.testBit15Zero = instr[1];
          strobes.testBit0Zero  = instr[0];
        end
        MODE_CLRCPL: begin
          strobes.clrReg     = instr[8];
          strobes.cplReg     = instr[7];
          strobes.clrCarry   = instr[6];
          strobes.cplCarry   = instr[5];
          strobes.skipAlways = instr[4];
          strobes.swapHalves = instr[3];
          strobes.clrSign    = instr[2];
          strobes.cplSign    = instr[1];
          strobes.orSw       = instr[0];
        end
        MODE_ALTER: begin
          strobes.senseTrue   = instr[8];
          strobes.testNeg     = instr[7];
          strobes.testNonZero = instr[6];
          strobes.testCarry   = instr[5];
          strobes.testGt      = instr[3];
          strobes.clrGt       = instr[2];
          strobes.clrReg      = instr[1];
          strobes.cplReg      = instr[0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/regop_datapath.sv
module regop_datapath
  import regop_pkg::*;
#(
  parameter int WIDTH = 17
) (
  input  strobes_t           strobes,
  input  logic [WIDTH-1:0]   aIn,
  input  logic [WIDTH-1:0]   bIn,
  input  logic [WIDTH-1:0]   swIn,
  input  logic               carryIn,
  input  logic               gtIn,
  output logic [WIDTH-1:0]   aNext,
  output logic [WIDTH-1:0]   bNext,
  output logic               carryNext,
  output logic               gtNext,
  output logic               skipNext
);
  localparam int HALF    = WIDTH / 2;
  localparam int SIGN    = WIDTH - 1;
  localparam int TESTHI  = WIDTH - 2;

  logic [WIDTH-1:0] opVal, afterInc, afterRot, swapped, finalVal;
  logic             cMid, cRot, cFinal, gFinal;
  logic             anyMet, anyTest;

  // half swap: upper HALF bits trade places with lower HALF; odd middle bit stays
  generate
    if (WIDTH % 2 == 1) begin : g_oddSwap
      assign swapped = {afterRot[HALF-1:0], afterRot[HALF], afterRot[WIDTH-1:HALF+1]};
    end else begin : g_evenSwap
      assign swapped = {afterRot[HALF-1:0], afterRot[WIDTH-1:HALF]};
    end
  endgenerate

  always_comb begin
    opVal = strobes.selA ? aIn : bIn;
    cMid  = strobes.clrCarry ? 1'b0 : carryIn;
    if (strobes.clrReg) opVal = '0;
    if (strobes.orSw)   opVal = opVal | swIn;
    if (strobes.cplReg) opVal = ~opVal;
    afterInc = opVal;
    if (strobes.incReg) afterInc = afterInc + WIDTH'(1);
    if (strobes.decReg) afterInc = afterInc - WIDTH'(1);
  end

  always_comb begin
    afterRot = afterInc;
    cRot     = cMid;
    if (strobes.rotEn) begin
      if (strobes.thruCarry) begin
        if (strobes.leftDir) begin
          afterRot = {afterInc[WIDTH-2:0], cMid};
          cRot     = afterInc[WIDTH-1];
        end else begin
          afterRot = {cMid, afterInc[WIDTH-1:1]};
          cRot     = afterInc[0];
        end
      end else if (strobes.leftDir) begin
        afterRot = {afterInc[WIDTH-2:0], afterInc[WIDTH-1]};
      end else begin
        afterRot = {afterInc[0], afterInc[WIDTH-1:1]};
      end
    end else if (strobes.shiftEn) begin
      if (strobes.leftDir) begin
        afterRot = {afterInc[WIDTH-2:0], 1'b0};
        cRot     = afterInc[WIDTH-1];
      end else begin
        afterRot = {1'b0, afterInc[WIDTH-1:1]};
        cRot     = afterInc[0];
      end
    end
  end

  always_comb begin
    finalVal = strobes.swapHalves ? swapped : afterRot;
    if (strobes.clrSign) finalVal[SIGN] = 1'b0;
    if (strobes.cplSign) finalVal[SIGN] = ~finalVal[SIGN];
    cFinal = strobes.cplCarry ? ~cRot : cRot;
    gFinal = strobes.clrGt ? 1'b0 : gtIn;

    anyMet  = (strobes.testNeg     &  finalVal[SIGN])
            | (strobes.testNonZero & (|finalVal))
            | (strobes.testCarry   &  cFinal)
            | (strobes.testGt      &  gFinal);
    anyTest = strobes.testNeg | strobes.testNonZero | strobes.testCarry | strobes.testGt;

    skipNext = strobes.skipAlways
             | (strobes.testBit15Zero & ~finalVal[TESTHI])
             | (strobes.testBit0Zero  & ~finalVal[0])
             | (strobes.senseTrue ? anyMet : (anyTest & ~anyMet));
  end

  assign aNext     = strobes.selA ? finalVal : aIn;
  assign bNext     = strobes.selA ? bIn : finalVal;
  assign carryNext = cFinal;
  assign gtNext    = gFinal;
endmodule

// File: rtl/regop_unit.sv
module regop_unit
  import regop_pkg::*;
#(
  parameter int WIDTH   = 17,
  parameter int INSTR_W = 17
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [INSTR_W-1:0] instr,
  input  logic [WIDTH-1:0]   aIn,
  input  logic [WIDTH-1:0]   bIn,
  input  logic [WIDTH-1:0]   swIn,
  input  logic               carryIn,
  input  logic               gtIn,
  output logic [WIDTH-1:0]   aOut,
  output logic [WIDTH-1:0]   bOut,
  output logic               carryOut,
  output logic               gtOut,
  output logic               skipOut
);
  strobes_t         strobes;
  logic [WIDTH-1:0] aNext, bNext;
  logic             carryNext, gtNext, skipNext;

  regop_ctrl #(.INSTR_W(INSTR_W)) u_ctrl (
    .instr   (instr),
    .strobes (strobes)
  );

  regop_datapath #(.WIDTH(WIDTH)) u_dp (
    .strobes   (strobes),
    .aIn       (aIn),
    .bIn       (bIn),
    .swIn      (swIn),
    .carryIn   (carryIn),
    .gtIn      (gtIn),
    .aNext     (aNext),
    .bNext     (bNext),
    .carryNext (carryNext),
    .gtNext    (gtNext),
    .skipNext  (skipNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aOut     <= '0;
      bOut     <= '0;
      carryOut <= 1'b0;
      gtOut    <= 1'b0;
      skipOut  <= 1'b0;
    end else begin
      aOut     <= aNext;
      bOut     <= bNext;
      carryOut <= carryNext;
      gtOut    <= gtNext;
      skipOut  <= skipNext;
    end
  end
endmodule

// File: rtl/regop_checker.sv
module regop_checker #(
  parameter int WIDTH   = 17,
  parameter int INSTR_W = 17
) (
  input logic               clk,
  input logic               rstN,
  input logic [INSTR_W-1:0] instr,
  input logic [WIDTH-1:0]   aIn,
  input logic [WIDTH-1:0]   bIn,
  input logic               carryIn,
  input logic               gtIn,
  input logic [WIDTH-1:0]   aOut,
  input logic [WIDTH-1:0]   bOut,
  input logic               carryOut,
  input logic               gtOut,
  input logic               skipOut
);
  logic       isReg;
  logic [1:0] mode;
  assign isReg = (instr[INSTR_W-1:12] == '0);
  assign mode  = instr[11:10];

  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!isReg || mode == 2'b00) |=> (aOut == $past(aIn) && bOut == $past(bIn) &&
      carryOut == $past(carryIn) && gtOut == $past(gtIn) && !skipOut));

  assert_keep_b_R3: assert property (@(posedge clk) disable iff (!rstN)
    instr[9] |=> bOut == $past(bIn));

  assert_keep_a_R3: assert property (@(posedge clk) disable iff (!rstN)
    !instr[9] |=> aOut == $past(aIn));

  assert_inc_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (isReg && mode == 2'b01 && instr[9] && instr[8:0] == 9'b000000100)
      |=> aOut == $past(aIn) + WIDTH'(1));

  assert_skip_always_R9: assert property (@(posedge clk) disable iff (!rstN)
    (isReg && mode == 2'b10 && instr[4]) |=> skipOut);

  assert_gt_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(isReg && mode == 2'b11) |=> gtOut == $past(gtIn));

  assert_gt_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (isReg && mode == 2'b11 && instr[2]) |=> !gtOut);

  assert_carry_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (isReg && mode == 2'b11) |=> carryOut == $past(carryIn));
endmodule

bind regop_unit regop_checker #(.WIDTH(WIDTH), .INSTR_W(INSTR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .instr    (instr),
  .aIn      (aIn),
  .bIn      (bIn),
  .carryIn  (carryIn),
  .gtIn     (gtIn),
  .aOut     (aOut),
  .bOut     (bOut),
  .carryOut (carryOut),
  .gtOut    (gtOut),
  .skipOut  (skipOut)
);

// File: tb/regop_unit_bench.sv
module regop_unit_bench;
  localparam int W = 17;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [16:0]   instr = '0;
  logic [W-1:0]  aIn = '0, bIn = '0, swIn = '0;
  logic          carryIn = 1'b0, gtIn = 1'b0;
  logic [W-1:0]  aOut, bOut;
  logic          carryOut, gtOut, skipOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         c;
    logic         g;
    logic         s;
  } res_t;

  always #4 clk = ~clk;

  regop_unit u_regop_unit (
    .clk(clk), .rstN(rstN), .instr(instr), .aIn(aIn), .bIn(bIn), .swIn(swIn),
    .carryIn(carryIn), .gtIn(gtIn), .aOut(aOut), .bOut(bOut),
    .carryOut(carryOut), .gtOut(gtOut), .skipOut(skipOut)
  );

  function automatic logic [16:0] mk(input logic [1:0] md, input logic sel, input logic [8:0] bits);
    return {5'd0, md, sel, bits};
  endfunction

  function automatic res_t model(input logic [16:0] ins, input logic [W-1:0] a, input logic [W-1:0] b,
                                 input logic [W-1:0] sw, input logic c, input logic g);
    res_t r;
    logic [W-1:0] v, t;
    logic ct, met, en;
    v = ins[9] ? a : b;
    r.s = 1'b0;
    if (ins[16:12] == 5'd0) begin
      case (ins[11:10])
        2'b01: begin
          if (ins[8]) c = 1'b0;
          if (ins[2]) v = v + 17'd1;
          if (ins[3]) v = v - 17'd1;
          if (ins[5]) begin
            if (ins[4]) begin
              if (ins[7]) begin ct = v[16]; v = {v[15:0], c}; c = ct; end
              else        begin ct = v[0];  v = {c, v[16:1]}; c = ct; end
            end else if (ins[7]) v = {v[15:0], v[16]};
            else                 v = {v[0], v[16:1]};
          end else if (ins[6]) begin
            if (ins[7]) begin c = v[16]; v = v << 1; end
            else        begin c = v[0];  v = v >> 1; end
          end
          r.s = (ins[1] && !v[15]) || (ins[0] && !v[0]);
        end
        2'b10: begin
          if (ins[8]) v = '0;
          if (ins[0]) v = v | sw;
          if (ins[7]) v = ~v;
          if (ins[3]) begin t = v; v = {t[7:0], t[8], t[16:9]}; end
          if (ins[2]) v[16] = 1'b0;
          if (ins[1]) v[16] = ~v[16];
          if (ins[6]) c = 1'b0;
          if (ins[5]) c = ~c;
          r.s = ins[4];
        end
        2'b11: begin
          if (ins[1]) v = '0;
          if (ins[0]) v = ~v;
          if (ins[2]) g = 1'b0;
          met = (ins[7] && v[16]) || (ins[6] && v != 0) || (ins[5] && c) || (ins[3] && g);
          en  = ins[7] | ins[6] | ins[5] | ins[3];
          r.s = ins[8] ? met : (en && !met);
        end
        default: ;
      endcase
    end
    r.a = ins[9] ? v : a;
    r.b = ins[9] ? b : v;
    r.c = c;
    r.g = g;
    return r;
  endfunction

  task automatic compare(input string tag, input res_t exp);
    res_t got;
    got = '{a: aOut, b: bOut, c: carryOut, g: gtOut, s: skipOut};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s instr=%o: got a=%h b=%h c=%b g=%b s=%b expected a=%h b=%h c=%b g=%b s=%b",
               tag, instr, got.a, got.b, got.c, got.g, got.s, exp.a, exp.b, exp.c, exp.g, exp.s);
    end
  endtask

  task automatic run(input string tag, input logic [16:0] ins, input logic [W-1:0] a,
                     input logic [W-1:0] b, input logic [W-1:0] sw, input logic c, input logic g);
    res_t exp;
    @(negedge clk);
    instr = ins; aIn = a; bIn = b; swIn = sw; carryIn = c; gtIn = g;
    exp = model(ins, a, b, sw, c, g);
    @(negedge clk);
    compare(tag, exp);
  endtask

  task automatic expectExact(input string tag, input res_t exp);
    compare(tag, exp);
  endtask

  initial begin
    instr = mk(2'b10, 1'b1, 9'o777); aIn = 17'h1ABCD; bIn = 17'h0F0F0; carryIn = 1'b1; gtIn = 1'b1;
    repeat (3) @(negedge clk);
    expectExact("R1 reset", '{a: '0, b: '0, c: 1'b0, g: 1'b0, s: 1'b0});
    rstN = 1'b1;

    // R2 pass-through: mode 00 and a memory-reference opcode
    run("R2 mode00", mk(2'b00, 1'b1, 9'o777), 17'h12345, 17'h0ABCD, 17'h1FFFF, 1'b1, 1'b1);
    run("R2 opcode", {5'd2, 2'b11, 1'b1, 9'o777}, 17'h12345, 17'h0ABCD, 17'h1FFFF, 1'b1, 1'b1);
    expectExact("R2 opcode hand", '{a: 17'h12345, b: 17'h0ABCD, c: 1'b1, g: 1'b1, s: 1'b0});
    // R3 select B for a clear
    run("R3 clear B", mk(2'b10, 1'b0, 9'o400), 17'h12345, 17'h0ABCD, 17'h0, 1'b0, 1'b0);
    expectExact("R3 clear B hand", '{a: 17'h12345, b: '0, c: 1'b0, g: 1'b0, s: 1'b0});
    // R4 wrap and cancel
    run("R4 inc wrap", mk(2'b01, 1'b1, 9'o004), 17'h1FFFF, 17'h0, 17'h0, 1'b0, 1'b0);
    expectExact("R4 inc wrap hand", '{a: '0, b: '0, c: 1'b0, g: 1'b0, s: 1'b0});
    run("R4 dec wrap", mk(2'b01, 1'b0, 9'o010), 17'h0, 17'h0, 17'h0, 1'b0, 1'b0);
    run("R4 inc+dec", mk(2'b01, 1'b1, 9'o014), 17'h0555A, 17'h0, 17'h0, 1'b1, 1'b0);
    // R5 shifts
    run("R5 left shift", mk(2'b01, 1'b1, 9'o300), 17'h10001, 17'h0, 17'h0, 1'b0, 1'b0);
    expectExact("R5 left shift hand", '{a: 17'h00002, b: '0, c: 1'b1, g: 1'b0, s: 1'b0});
    run("R5 right shift", mk(2'b01, 1'b1, 9'o100), 17'h10001, 17'h0, 17'h0, 1'b0, 1'b0);
    run("R5 clc+inc+left", mk(2'b01, 1'b0, 9'o704), 17'h0, 17'h0FFFF, 17'h0, 1'b1, 1'b0);
    // R6 rotates
    run("R6 rot right", mk(2'b01, 1'b1, 9'o040), 17'h00001, 17'h0, 17'h0, 1'b0, 1'b0);
    run("R6 rot left carry", mk(2'b01, 1'b1, 9'o260), 17'h10000, 17'h0, 17'h0, 1'b1, 1'b0);
    expectExact("R6 rot left carry hand", '{a: 17'h00001, b: '0, c: 1'b1, g: 1'b0, s: 1'b0});
    run("R6 rot over shift", mk(2'b01, 1'b1, 9'o160), 17'h00001, 17'h0, 17'h0, 1'b0, 1'b0);
    // R7 bit tests
    run("R7 bit0 zero", mk(2'b01, 1'b1, 9'o001), 17'h00002, 17'h0, 17'h0, 1'b0, 1'b0);
    run("R7 bit15 set", mk(2'b01, 1'b1, 9'o002), 17'h08000, 17'h0, 17'h0, 1'b0, 1'b0);
    // R8 clear/complement group
    run("R8 swap", mk(2'b10, 1'b1, 9'o010), 17'h1FE00, 17'h0, 17'h0, 1'b0, 1'b0);
    expectExact("R8 swap hand", '{a: 17'h000FF, b: '0, c: 1'b0, g: 1'b0, s: 1'b0});
    run("R8 swap mid", mk(2'b10, 1'b1, 9'o010), 17'h00100, 17'h0, 17'h0, 1'b0, 1'b0);
    run("R8 clear+switch", mk(2'b10, 1'b1, 9'o401), 17'h1FFFF, 17'h0, 17'h0ACE1, 1'b0, 1'b0);
    run("R8 sign ops", mk(2'b10, 1'b0, 9'o206), 17'h00F0F, 17'h00F0F, 17'h0, 1'b0, 1'b0);
    // R9 carry and skip
    run("R9 clc+cmc+skip", mk(2'b10, 1'b1, 9'o160), 17'h0, 17'h0, 17'h0, 1'b0, 1'b0);
    // R10 alter
    run("R10 cpl+clrgt", mk(2'b11, 1'b1, 9'o005), 17'h0F0F0, 17'h0, 17'h0, 1'b1, 1'b1);
    // R11 skip sense
    run("R11 clr no skip", mk(2'b11, 1'b1, 9'o002), 17'h12345, 17'h0, 17'h0, 1'b0, 1'b0);
    expectExact("R11 clr no skip hand", '{a: '0, b: '0, c: 1'b0, g: 1'b0, s: 1'b0});
    run("R11 positive", mk(2'b11, 1'b1, 9'o200), 17'h0FFFF, 17'h0, 17'h0, 1'b0, 1'b0);
    run("R11 any true", mk(2'b11, 1'b0, 9'o450), 17'h0, 17'h0, 17'h0, 1'b0, 1'b1);
    run("R11 none false", mk(2'b11, 1'b0, 9'o050), 17'h0, 17'h0, 17'h0, 1'b0, 1'b1);
    run("R11 gt after clear", mk(2'b11, 1'b1, 9'o414), 17'h1, 17'h0, 17'h0, 1'b0, 1'b1);
    run("R11 bit4 ignored", mk(2'b11, 1'b1, 9'o020), 17'h1, 17'h0, 17'h0, 1'b1, 1'b1);

    begin
      int seed = 32'h5EED;
      void'($urandom(seed));
    end
    for (int i = 0; i < 3000; i++) begin
      logic [16:0] ins;
      string tag;
      ins = 17'($urandom());
      if ($urandom_range(7) != 0) ins[16:12] = 5'd0;
      case (ins[11:10])
        2'b00:   tag = "R2 R3 random";
        2'b01:   tag = "R4 R5 R6 R7 random";
        2'b10:   tag = "R8 R9 random";
        default: tag = "R10 R11 random";
      endcase
      if (ins[16:12] != 5'd0) tag = "R2 random opcode";
      run(tag, ins, 17'($urandom()), 17'($urandom()), 17'($urandom()),
          1'($urandom()), 1'($urandom()));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule